// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port

This block is a byte-wide general-purpose I/O port without a direction register. Each bit keeps one stored value that also sets its pad. A stored 0 turns on a strong pull-down, so the pin is held at ground. A stored 1 releases the pin. With a stored 1, either a weak internal pull-up or an external resistor pulls the pin high. To use a bit as an input, software writes a 1 to it and then reads the pin. An external device that drives the pin low then reads back as 0, while the stored value stays 1.

The CPU side has four operations:
- a plain write strobe with data;
- a read-modify-write strobe that combines the stored value with an operand;
- a read-pin strobe that returns the synchronized pad level;
- a read-latch strobe that returns the stored value.

Reads are registered onto one read bus. The pad side drives a pull-down enable and a weak pull-up enable for each bit, and takes the raw pin level back through a synchronizer. A parameter chooses between the variant with an internal pull-up and the open-drain variant.

Top module: `qb_gpio_port`

## Requirements
- R1: After reset the stored value of every bit is 1. Every pull-down enable is 0, the read bus is 0, and the synchronizer holds all ones.
- R2: When `wr_en` is high at a rising edge, the stored value takes `wr_data`. From the next cycle `pd_en` equals the inverse of the stored value.
- R3: With `PULLUP_EN=1`, `pu_en` equals the stored value. With `PULLUP_EN=0` (open drain), `pu_en` is always all zeros.
- R4: A pin level passes through `SYNC_STAGES` (default 2) flops before the read-pin path sees it. A read-pin strobe issued one edge after a pin change still returns the old level.
- R5: A read-latch strobe returns the stored value, not the pin, even when an external device holds the pin low. When both read strobes are high, read-latch wins.
- R6: `rd_data` changes only at an edge where a read strobe is high. Otherwise it holds its value.
- R7: A read-modify-write takes its old value from the stored value, never from the pins. `rmw_op` encodings: 0 = AND, 1 = OR, 2 = XOR, 3 = keep.
- R8: When `wr_en` and `rmw_en` are high in the same cycle, the plain write wins.
- R9: A read-latch strobe in the same cycle as a write returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Plain write strobe |
| wr_data | input | WIDTH | Data for the plain write |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 2 | Read-modify-write operation: 0 AND, 1 OR, 2 XOR, 3 keep |
| rmw_arg | input | WIDTH | Operand for the read-modify-write |
| rd_pin_en | input | 1 | Read the synchronized pin level |
| rd_latch_en | input | 1 | Read the stored value |
| pin_in | input | WIDTH | Raw pad level, asynchronous |
| pd_en | output | WIDTH | Strong pull-down enable for each bit |
| pu_en | output | WIDTH | Weak pull-up enable for each bit |
| rd_data | output | WIDTH | Registered read bus |

## Verification
Two pairs of functions can land in the same cycle.

A write and a read-latch can coincide. The bench raises both strobes at one falling edge and expects the pre-write value on the read bus, then the new value on the following read. A plain write and a read-modify-write can also coincide. Here the bench expects the write data, with no trace of the operand.

The bench models the pad as a wired-AND of the pull-down, an external low driver and the pull-up. It compares read-pin against read-latch while pins are held low externally.

// File: rtl/qb_gpio_pkg.sv
`timescale 1ns/1ps
// Shared types for the quasi-bidirectional port.
package qb_gpio_pkg;
    // Read-modify-write operation encoding (R7).
    typedef enum logic [1:0] {
        RMW_AND  = 2'd0,
        RMW_OR   = 2'd1,
        RMW_XOR  = 2'd2,
        RMW_KEEP = 2'd3
    } rmw_op_e;
endpackage

// File: rtl/qb_gpio_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the raw pad levels.
// Assumes STAGES >= 2. Resets to all ones, because released pins read high.
module qb_gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage: capture the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '1;
        else        chain[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages: shift the value along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

    // R4: the output is the input delayed by exactly STAGES edges (shown here for two).
    a_r4_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && $past(rst_n) && $past(rst_n, 2)) |-> sync_out == $past(raw_in, 2));
endmodule

// File: rtl/qb_gpio_latch.sv
`timescale 1ns/1ps
// Output latch bank. A plain write has priority over a read-modify-write.
// The read-modify-write combines the stored value, never the pins.
module qb_gpio_latch
    import qb_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  rmw_op_e          rmw_op,
    input  logic [WIDTH-1:0] rmw_arg,
    output logic [WIDTH-1:0] latch_q
);
    logic [WIDTH-1:0] rmw_result;

    // Combine the stored value with the operand.
    always_comb begin
        unique case (rmw_op)
            RMW_AND: rmw_result = latch_q & rmw_arg;
            RMW_OR:  rmw_result = latch_q | rmw_arg;
            RMW_XOR: rmw_result = latch_q ^ rmw_arg;
            default: rmw_result = latch_q;
        endcase
    end

    // Store: reset to released, then write, then read-modify-write.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '1;
        else if (wr_en)  latch_q <= wr_data;
        else if (rmw_en) latch_q <= rmw_result;
    end

    a_r1_reset_released: assert property (@(posedge clk)
        !rst_n |=> latch_q == '1);
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> latch_q == $past(wr_data));
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rmw_en) |=> $stable(latch_q));
    a_r7_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rmw_en && rmw_op == RMW_KEEP) |=> $stable(latch_q));
endmodule

// File: rtl/qb_gpio_readmux.sv
`timescale 1ns/1ps
// Registered read bus. Read-latch has priority over read-pin.
// The bus holds its value when neither strobe is high.
module qb_gpio_readmux #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pin_en,
    input  logic             rd_latch_en,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rd_data
);
    // Capture the selected source on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           rd_data <= '0;
        else if (rd_latch_en) rd_data <= latch_q;
        else if (rd_pin_en)   rd_data <= pin_sync;
    end

    a_r5_latch_path: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch_en |=> rd_data == $past(latch_q));
    a_r4_pin_path: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pin_en && !rd_latch_en) |=> rd_data == $past(pin_sync));
    a_r6_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pin_en && !rd_latch_en) |=> $stable(rd_data));
endmodule

// File: rtl/qb_gpio_port.sv
`timescale 1ns/1ps
// Quasi-bidirectional byte port: one latch per bit drives the pad.
// A stored 0 pulls the pin down; a stored 1 releases it to the pull-up (or to an
// external resistor in the open-drain variant). Assumes pin_in is asynchronous.
module qb_gpio_port
    import qb_gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit PULLUP_EN   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_arg,
    input  logic             rd_pin_en,
    input  logic             rd_latch_en,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pd_en,
    output logic [WIDTH-1:0] pu_en,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;

    qb_gpio_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rmw_en  (rmw_en),
        .rmw_op  (rmw_op_e'(rmw_op)),
        .rmw_arg (rmw_arg),
        .latch_q (latch_q)
    );

    qb_gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    qb_gpio_readmux #(.WIDTH(WIDTH)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_pin_en   (rd_pin_en),
        .rd_latch_en (rd_latch_en),
        .latch_q     (latch_q),
        .pin_sync    (pin_sync),
        .rd_data     (rd_data)
    );

    // Pad drivers: strong low for a stored 0.
    assign pd_en = ~latch_q;

    // Weak pull-up exists only in the pulled-up variant.
    if (PULLUP_EN) begin : g_pullup
        assign pu_en = latch_q;
    end else begin : g_open_drain
        assign pu_en = '0;
    end

    a_r2_pulldown_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pd_en == ~$past(wr_data));
    a_r3_pullup_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && PULLUP_EN) |=> pu_en == $past(wr_data));
    a_r8_write_beats_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rmw_en) |=> pd_en == ~$past(wr_data));
endmodule

// File: tb/qb_gpio_port_bench.sv
`timescale 1ns/1ps
module qb_gpio_port_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rmw_en = 1'b0, rd_pin_en = 1'b0, rd_latch_en = 1'b0;
    logic [W-1:0] wr_data = '0, rmw_arg = '0, ext_low = '0;
    logic [1:0]   rmw_op = 2'd3;
    logic [W-1:0] pd_en, pu_en, rd_data, pin_pad;
    logic [W-1:0] pd_od, pu_od, rd_od, pin_od;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    // Pad model: wired-AND of the pull-down and an external low driver, with the pull-up.
    assign pin_pad = ~pd_en & ~ext_low & pu_en;
    // Open-drain pad with an external resistor to the supply.
    assign pin_od  = ~pd_od & ~ext_low;

    qb_gpio_port u_qb_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg),
        .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .pin_in(pin_pad),
        .pd_en(pd_en), .pu_en(pu_en), .rd_data(rd_data));

    qb_gpio_port #(.PULLUP_EN(1'b0)) u_od (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg),
        .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .pin_in(pin_od),
        .pd_en(pd_od), .pu_en(pu_od), .rd_data(rd_od));

    // Vectors: {write data, external-low mask, expected latch read, expected pin read}.
    localparam logic [31:0] VEC [6] = '{
        {8'hFF, 8'h00, 8'hFF, 8'hFF},
        {8'h00, 8'h00, 8'h00, 8'h00},
        {8'hFF, 8'h0F, 8'hFF, 8'hF0},
        {8'hA5, 8'h00, 8'hA5, 8'hA5},
        {8'hF0, 8'h3C, 8'hF0, 8'hC0},
        {8'h5A, 8'hFF, 8'h5A, 8'h00}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_rmw(input logic [1:0] op, input logic [W-1:0] arg);
        @(negedge clk); rmw_en = 1'b1; rmw_op = op; rmw_arg = arg;
        @(negedge clk); rmw_en = 1'b0;
    endtask

    task automatic read_latch(output logic [W-1:0] v);
        @(negedge clk); rd_latch_en = 1'b1;
        @(negedge clk); rd_latch_en = 1'b0; v = rd_data;
    endtask

    task automatic read_pin(output logic [W-1:0] v);
        @(negedge clk); rd_pin_en = 1'b1;
        @(negedge clk); rd_pin_en = 1'b0; v = rd_data;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset.
        check("R1 pd_en", pd_en, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        check("R3 pu_en", pu_en, 8'hFF);
        check("R3 open-drain pu_en", pu_od, 8'h00);
        read_latch(v); check("R1 latch", v, 8'hFF);

        // R2, R4, R5: vector table, read-pin against read-latch.
        for (int i = 0; i < 6; i++) begin
            ext_low = VEC[i][23:16];
            do_write(VEC[i][31:24]);
            check("R2 pd_en", pd_en, ~VEC[i][31:24]);
            check("R3 pu_en", pu_en, VEC[i][31:24]);
            settle();
            read_latch(v); check("R5 latch", v, VEC[i][15:8]);
            read_pin(v);   check("R4 pin", v, VEC[i][7:0]);
        end
        check("R3 open-drain pu_en after writes", pu_od, 8'h00);
        read_pin(v);
        ext_low = 8'h00;
        settle();
        read_pin(v);  // open-drain instance reads through its external resistor
        check("R3 open-drain pin", rd_od, 8'h5A);

        // R4: synchronizer latency.
        do_write(8'hFF); ext_low = 8'h00; settle();
        read_pin(v); check("R4 pin idle high", v, 8'hFF);
        @(negedge clk); ext_low = 8'h81;
        @(negedge clk); rd_pin_en = 1'b1;
        @(negedge clk); check("R4 old level one edge after change", rd_data, 8'hFF);
        @(negedge clk); rd_pin_en = 1'b0;
        check("R4 new level after two edges", rd_data, 8'h7E);

        // R5: both strobes together, pins held low, latch wins.
        @(negedge clk); rd_pin_en = 1'b1; rd_latch_en = 1'b1;
        @(negedge clk); rd_pin_en = 1'b0; rd_latch_en = 1'b0;
        check("R5 latch priority", rd_data, 8'hFF);

        // R6: pin change without a strobe leaves the bus alone.
        ext_low = 8'h00; settle();
        check("R6 bus holds", rd_data, 8'hFF);
        read_pin(v); ext_low = 8'hFF; settle();
        check("R6 bus holds after pin read", rd_data, 8'hFF);

        // R7: read-modify-write uses the latch, with all pins held low.
        do_write(8'hF0); ext_low = 8'hFF; settle();
        do_rmw(2'd1, 8'h0F); read_latch(v); check("R7 OR", v, 8'hFF);
        do_rmw(2'd0, 8'h3C); read_latch(v); check("R7 AND", v, 8'h3C);
        do_rmw(2'd2, 8'hFF); read_latch(v); check("R7 XOR", v, 8'hC3);
        do_rmw(2'd3, 8'h00); read_latch(v); check("R7 keep", v, 8'hC3);
        ext_low = 8'h00;

        // R8: write and read-modify-write together.
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h66; rmw_en = 1'b1; rmw_op = 2'd1; rmw_arg = 8'h81;
        @(negedge clk); wr_en = 1'b0; rmw_en = 1'b0;
        read_latch(v); check("R8 write wins", v, 8'h66);

        // R9: read-latch in the write cycle returns the old value.
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h33; rd_latch_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; rd_latch_en = 1'b0;
        check("R9 old value", rd_data, 8'h66);
        read_latch(v); check("R9 new value", v, 8'h33);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule